// File: doc/BRIEF.md
# Change-of-State Input Interrupt Controller

This block samples a 32-bit digital input port and raises one level interrupt when the lower 16 channels change state in a way software has armed. Each interruptible channel has one bit in each of two condition masks. Their meaning depends on a combining mode. In edge mode, the first mask arms rising edges and the second arms falling edges, and any armed edge fires. In level mode, the first mask asks for a high level and the second for a low level, and the block fires only when every armed channel holds its requested level at the same time.

Software works the block through a small 32-bit register bus. It can read the synchronized inputs, both masks, a status word and a control word. When the interrupt fires, the status word captures the state of the 16 interruptible channels and keeps it until software reads it. That read clears the pending interrupt. In level mode, the block locks after it fires. It does not fire again until one of the armed inputs changes level, so a condition that simply stays true cannot cause an interrupt storm.

Top module: `cosIrqCtrl`

## Requirements
- R1: After reset, `irqOut` is low and the mask registers, the control register and the status register all read zero.
- R2: A read at byte address 0x00 returns all 32 input pins, seen after a two-flop synchronizer.
- R3: The mask registers (0x04 first mask, 0x08 second mask) keep only bits 15:0, and their bits 31:16 read zero. The control register (0x10) keeps only bit 1 (mode: 0 edge, 1 level) and bit 2 (enable), and all its other bits read zero.
- R4: In edge mode with the block enabled, a rising edge on a channel set in the first mask raises `irqOut` on the third clock edge after the pin changes.
- R5: In edge mode, a falling edge on a channel set in the second mask fires. A channel set in both masks fires on either edge. An edge on a channel set in neither mask does not fire.
- R6: Pins 16 to 31 never cause an interrupt, whatever is written to the masks.
- R7: In level mode, the interrupt fires when every channel set in the first mask is high and every channel set in the second mask is low. If any armed channel is at the wrong level, it does not fire.
- R8: After a level-mode interrupt, the block does not fire again while the condition stays true. A level change on an unarmed channel does not release it. A level change on an armed channel releases it, and the next time the condition becomes true, the block fires again.
- R9: The status register (0x0C) holds the channel 15:0 state captured when the interrupt fired in bits 15:0, with the pending flag in bit 16. `irqOut` stays high until software reads 0x0C. That read drops `irqOut`, and the status then reads zero.
- R10: While control bit 2 is zero, no interrupt fires. Setting it again arms only events that happen after the write.
- R11: In level mode, a channel set in both masks makes the level condition impossible, so the block never fires.
- R12: While an interrupt is pending, later events do not overwrite the captured status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinIn | input | 32 | Asynchronous digital input pins |
| busWrEn | input | 1 | Register write strobe |
| busRdEn | input | 1 | Register read strobe; a read of status clears it at the clock edge |
| busAddr | input | 5 | Register byte address |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data, combinational from the address |
| irqOut | output | 1 | Level interrupt, high while an event is pending |

## Verification
A wrong pending or lock flag shows up at the ports as an interrupt that is missing, that repeats, or that does not drop after the status read, and the bench catches it within a few cycles of the triggering pin change. A wrong capture shows up as a status word that does not match the channel pattern the bench drove. A mask or mode bit that was decoded wrongly shows up as a wrong readback, or as a fire or silence that does not fit the driven pattern. Each scenario starts from a cleared configuration, so a stale lock or pending flag cannot hide a fault in the next scenario.

// File: rtl/cosPkg.sv
package cosPkg;
  localparam int ADDR_W = 5;
  typedef logic [ADDR_W-1:0] addr_t;

  localparam addr_t ADDR_RAW    = 5'h00;
  localparam addr_t ADDR_RISEHI = 5'h04;
  localparam addr_t ADDR_FALLLO = 5'h08;
  localparam addr_t ADDR_STATUS = 5'h0C;
  localparam addr_t ADDR_CTRL   = 5'h10;

  localparam int CTRL_MODE_BIT = 1;
  localparam int CTRL_EN_BIT   = 2;

  // Detection results handed from datapath to control
  typedef struct packed {
    logic orHit;
    logic andHit;
    logic armedChange;
  } cosEvent_t;

  // Strobes from control into the datapath
  typedef struct packed {
    logic capture;
    logic clear;
  } cosStrobe_t;

  typedef enum logic {LEVEL_OPEN = 1'b0, LEVEL_HELD = 1'b1} lockState_t;
endpackage

// File: rtl/cosDatapath.sv
module cosDatapath #(
  parameter int DATA_W      = 32,
  parameter int IRQ_CH      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [DATA_W-1:0]      pinIn,
  input  logic                   wrEn,
  input  cosPkg::addr_t          addr,
  input  logic [DATA_W-1:0]      wrData,
  input  cosPkg::cosStrobe_t     strobe,
  output logic [DATA_W-1:0]      rawOut,
  output logic [IRQ_CH-1:0]      maskHi,
  output logic [IRQ_CH-1:0]      maskLo,
  output logic [IRQ_CH-1:0]      statusVal,
  output cosPkg::cosEvent_t      events
);
  import cosPkg::*;

  logic [SYNC_STAGES-1:0][DATA_W-1:0] syncChain;
  logic [IRQ_CH-1:0] curLow, prevLow;
  logic [IRQ_CH-1:0] riseVec, fallVec, levelOk;

  // Multi-stage synchronizer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncChain <= '0;
    end else begin
      syncChain[0] <= pinIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncChain[s] <= syncChain[s-1];
    end
  end

  assign rawOut = syncChain[SYNC_STAGES-1];
  assign curLow = rawOut[IRQ_CH-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevLow <= '0;
    else       prevLow <= curLow;
  end

  // Per-channel edge and level qualification
  for (genvar ch = 0; ch < IRQ_CH; ch++) begin : gChan
    assign riseVec[ch] = curLow[ch] & ~prevLow[ch];
    assign fallVec[ch] = ~curLow[ch] & prevLow[ch];
    assign levelOk[ch] = (~maskHi[ch] | curLow[ch]) & (~maskLo[ch] | ~curLow[ch]);
  end

  always_comb begin
    events.orHit       = |((riseVec & maskHi) | (fallVec & maskLo));
    events.andHit      = (|(maskHi | maskLo)) & (&levelOk);
    events.armedChange = |((curLow ^ prevLow) & (maskHi | maskLo));
  end

  // Condition masks
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskHi <= '0;
      maskLo <= '0;
    end else if (wrEn) begin
      if (addr == ADDR_RISEHI) maskHi <= wrData[IRQ_CH-1:0];
      if (addr == ADDR_FALLLO) maskLo <= wrData[IRQ_CH-1:0];
    end
  end

  // Status snapshot
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              statusVal <= '0;
    else if (strobe.capture) statusVal <= curLow;
    else if (strobe.clear)   statusVal <= '0;
  end
endmodule

// File: rtl/cosControl.sv
module cosControl (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic               rdEn,
  input  cosPkg::addr_t      addr,
  input  logic               wrMode,
  input  logic               wrEnable,
  input  cosPkg::cosEvent_t  events,
  output cosPkg::cosStrobe_t strobe,
  output logic               ctrlEnable,
  output logic               ctrlAndMode,
  output logic               pending
);
  import cosPkg::*;

  lockState_t lockState;
  logic cfgWrite, statusRead, hit, fire;

  assign cfgWrite   = wrEn && (addr == ADDR_CTRL || addr == ADDR_RISEHI || addr == ADDR_FALLLO);
  assign statusRead = rdEn && (addr == ADDR_STATUS);

  always_comb begin
    if (ctrlAndMode) hit = events.andHit && (lockState == LEVEL_OPEN);
    else             hit = events.orHit;
    fire = ctrlEnable && !pending && hit;
    strobe.capture = fire;
    strobe.clear   = statusRead && !fire;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlEnable  <= 1'b0;
      ctrlAndMode <= 1'b0;
    end else if (wrEn && addr == ADDR_CTRL) begin
      ctrlEnable  <= wrEnable;
      ctrlAndMode <= wrMode;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           pending <= 1'b0;
    else if (fire)       pending <= 1'b1;
    else if (statusRead) pending <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      lockState <= LEVEL_OPEN;
    else if (cfgWrite)              lockState <= LEVEL_OPEN;
    else if (fire && ctrlAndMode)   lockState <= LEVEL_HELD;
    else if (events.armedChange)    lockState <= LEVEL_OPEN;
  end
endmodule

// File: rtl/cosIrqCtrl.sv
module cosIrqCtrl #(
  parameter int DATA_W      = 32,
  parameter int IRQ_CH      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [DATA_W-1:0]         pinIn,
  input  logic                      busWrEn,
  input  logic                      busRdEn,
  input  logic [cosPkg::ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0]         busWrData,
  output logic [DATA_W-1:0]         busRdData,
  output logic                      irqOut
);
  import cosPkg::*;

  cosEvent_t  events;
  cosStrobe_t strobe;
  logic [DATA_W-1:0] rawVal;
  logic [IRQ_CH-1:0] maskHi, maskLo, statusHeld;
  logic ctrlEnable, ctrlAndMode, pending;

  cosDatapath #(.DATA_W(DATA_W), .IRQ_CH(IRQ_CH), .SYNC_STAGES(SYNC_STAGES)) uDp (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .wrEn(busWrEn), .addr(busAddr),
    .wrData(busWrData), .strobe(strobe), .rawOut(rawVal), .maskHi(maskHi),
    .maskLo(maskLo), .statusVal(statusHeld), .events(events)
  );

  cosControl uCtl (
    .clk(clk), .rstN(rstN), .wrEn(busWrEn), .rdEn(busRdEn), .addr(busAddr),
    .wrMode(busWrData[CTRL_MODE_BIT]), .wrEnable(busWrData[CTRL_EN_BIT]),
    .events(events), .strobe(strobe), .ctrlEnable(ctrlEnable),
    .ctrlAndMode(ctrlAndMode), .pending(pending)
  );

  assign irqOut = pending;

  always_comb begin
    busRdData = '0;
    case (busAddr)
      ADDR_RAW:    busRdData = rawVal;
      ADDR_RISEHI: busRdData[IRQ_CH-1:0] = maskHi;
      ADDR_FALLLO: busRdData[IRQ_CH-1:0] = maskLo;
      ADDR_STATUS: begin
        busRdData[IRQ_CH-1:0] = statusHeld;
        busRdData[IRQ_CH]     = pending;
      end
      ADDR_CTRL: begin
        busRdData[CTRL_MODE_BIT] = ctrlAndMode;
        busRdData[CTRL_EN_BIT]   = ctrlEnable;
      end
      default: busRdData = '0;
    endcase
  end
endmodule

// File: rtl/cosIrqChecker.sv
module cosIrqChecker #(
  parameter int IRQ_CH = 16
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      rdEn,
  input logic [cosPkg::ADDR_W-1:0] addr,
  input logic                      irq,
  input logic                      enable,
  input logic [IRQ_CH-1:0]         statusHeld
);
  import cosPkg::*;

  logic statusRead;
  assign statusRead = rdEn && (addr == ADDR_STATUS);

  a_r1_reset_quiet: assert property (@(posedge clk) !rstN |=> !irq);

  a_r9_irq_sticky: assert property (@(posedge clk) disable iff (!rstN)
    irq && !statusRead |=> irq);

  a_r9_read_drops: assert property (@(posedge clk) disable iff (!rstN)
    irq && statusRead |=> !irq);

  a_r10_rise_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(enable));

  a_r12_status_frozen: assert property (@(posedge clk) disable iff (!rstN)
    irq && !statusRead |=> $stable(statusHeld));
endmodule

bind cosIrqCtrl cosIrqChecker #(.IRQ_CH(IRQ_CH)) uChk (
  .clk(clk), .rstN(rstN), .rdEn(busRdEn), .addr(busAddr), .irq(irqOut),
  .enable(ctrlEnable), .statusHeld(statusHeld)
);

// File: tb/tb_cosIrqCtrl.sv
module tb_cosIrqCtrl;
  import cosPkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [31:0] pinIn = '0;
  logic busWrEn = 1'b0, busRdEn = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic irqOut;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  cosIrqCtrl dut (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData), .irqOut(irqOut)
  );

  typedef struct packed {
    logic        andMode;
    logic [31:0] hi, lo, startPins, endPins;
    logic        expIrq;
    logic [31:0] expStatus;
    logic [23:0] tag;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 32'h1, 32'h0, 32'h0, 32'h1, 1'b1, 32'h10001, "R4"},          // R4 rise
    '{1'b0, 32'h0, 32'h2, 32'h2, 32'h0, 1'b1, 32'h10000, "R5"},          // R5 fall
    '{1'b0, 32'h4, 32'h4, 32'h4, 32'h0, 1'b1, 32'h10000, "R5"},          // R5 both masks
    '{1'b0, 32'h8, 32'h0, 32'h0, 32'h10, 1'b0, 32'h0, "R5"},             // R5 unarmed edge
    '{1'b0, 32'hFFFF, 32'h0, 32'h0, 32'h10000, 1'b0, 32'h0, "R6"},       // R6 high pin
    '{1'b0, 32'hFFFF0000, 32'h0, 32'h0, 32'hFFFF0000, 1'b0, 32'h0, "R6"},// R6 upper mask
    '{1'b1, 32'h3, 32'h4, 32'h4, 32'h3, 1'b1, 32'h10003, "R7"},          // R7 all met
    '{1'b1, 32'h3, 32'h4, 32'h4, 32'h7, 1'b0, 32'h0, "R7"},              // R7 one wrong
    '{1'b1, 32'h1, 32'h1, 32'h0, 32'h1, 1'b0, 32'h0, "R11"},             // R11 conflict
    '{1'b1, 32'hF0, 32'h0, 32'h0, 32'h000F00F0, 1'b1, 32'h100F0, "R7"}   // R7 extra pins
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic busWrite(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk);
    busRdEn = 1'b1; busAddr = a;
    #1 d = busRdData;
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  task automatic setPins(input logic [31:0] v);
    @(negedge clk);
    pinIn = v;
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cleanup();
    logic [31:0] d;
    busWrite(ADDR_CTRL, 32'h0);
    busWrite(ADDR_RISEHI, 32'h0);
    busWrite(ADDR_FALLLO, 32'h0);
    busRead(ADDR_STATUS, d);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
    end
  end

  initial begin
    logic [31:0] d;
    waitCycles(3);
    rstN = 1'b1;
    waitCycles(2);

    // R1 reset state
    check("R1 irq", {31'b0, irqOut}, 32'h0);
    busRead(ADDR_RISEHI, d); check("R1 mask hi", d, 32'h0);
    busRead(ADDR_FALLLO, d); check("R1 mask lo", d, 32'h0);
    busRead(ADDR_CTRL, d);   check("R1 ctrl", d, 32'h0);
    busRead(ADDR_STATUS, d); check("R1 status", d, 32'h0);

    // R2 raw inputs
    setPins(32'hA5A5_3C3C); waitCycles(3);
    busRead(ADDR_RAW, d); check("R2 raw a", d, 32'hA5A5_3C3C);
    setPins(32'h5A5A_C3C3); waitCycles(3);
    busRead(ADDR_RAW, d); check("R2 raw b", d, 32'h5A5A_C3C3);

    // R3 register widths
    busWrite(ADDR_RISEHI, 32'hFFFF_FFFF);
    busRead(ADDR_RISEHI, d); check("R3 mask hi", d, 32'h0000_FFFF);
    busWrite(ADDR_FALLLO, 32'h1234_8421);
    busRead(ADDR_FALLLO, d); check("R3 mask lo", d, 32'h0000_8421);
    busWrite(ADDR_CTRL, 32'hFFFF_FFFF);
    busRead(ADDR_CTRL, d); check("R3 ctrl", d, 32'h6);
    cleanup();

    // Table walk: R4 R5 R6 R7 R11
    for (int i = 0; i < NV; i++) begin
      cleanup();
      setPins(VECS[i].startPins); waitCycles(4);
      busWrite(ADDR_RISEHI, VECS[i].hi);
      busWrite(ADDR_FALLLO, VECS[i].lo);
      busWrite(ADDR_CTRL, {29'b0, 1'b1, VECS[i].andMode, 1'b0});
      waitCycles(3);
      setPins(VECS[i].endPins); waitCycles(5);
      check($sformatf("%s vec%0d irq", VECS[i].tag, i), {31'b0, irqOut}, {31'b0, VECS[i].expIrq});
      busRead(ADDR_STATUS, d);
      check($sformatf("%s vec%0d status", VECS[i].tag, i), d, VECS[i].expStatus);
    end

    // R8 level-mode lock and release
    cleanup();
    setPins(32'h0); waitCycles(4);
    busWrite(ADDR_RISEHI, 32'h1);
    busWrite(ADDR_CTRL, 32'h6);
    setPins(32'h1); waitCycles(5);
    check("R8 first fire", {31'b0, irqOut}, 32'h1);
    busRead(ADDR_STATUS, d); check("R8 first status", d, 32'h10001);
    waitCycles(6);
    check("R8 locked while true", {31'b0, irqOut}, 32'h0);
    setPins(32'h101); waitCycles(6);
    check("R8 unarmed change keeps lock", {31'b0, irqOut}, 32'h0);
    setPins(32'h100); waitCycles(6);
    check("R8 release no fire", {31'b0, irqOut}, 32'h0);
    setPins(32'h101); waitCycles(6);
    check("R8 refire", {31'b0, irqOut}, 32'h1);
    busRead(ADDR_STATUS, d); check("R8 refire status", d, 32'h10101);

    // R12 and R9: status held, then cleared by read
    cleanup();
    setPins(32'h0); waitCycles(4);
    busWrite(ADDR_RISEHI, 32'h3);
    busWrite(ADDR_CTRL, 32'h4);
    setPins(32'h1); waitCycles(5);
    setPins(32'h3); waitCycles(5);
    check("R9 irq held", {31'b0, irqOut}, 32'h1);
    busRead(ADDR_STATUS, d); check("R12 status kept", d, 32'h10001);
    waitCycles(1);
    check("R9 irq dropped", {31'b0, irqOut}, 32'h0);
    busRead(ADDR_STATUS, d); check("R9 status cleared", d, 32'h0);

    // R10 enable gating
    cleanup();
    setPins(32'h0); waitCycles(4);
    busWrite(ADDR_RISEHI, 32'h1);
    busWrite(ADDR_CTRL, 32'h0);
    setPins(32'h1); waitCycles(5);
    check("R10 disabled edge", {31'b0, irqOut}, 32'h0);
    busWrite(ADDR_CTRL, 32'h4); waitCycles(5);
    check("R10 enable no stale", {31'b0, irqOut}, 32'h0);
    setPins(32'h0); waitCycles(5);
    setPins(32'h1); waitCycles(5);
    check("R10 enabled edge", {31'b0, irqOut}, 32'h1);

    // R1 reset while pending
    @(negedge clk); rstN = 1'b0;
    waitCycles(2);
    check("R1 irq in reset", {31'b0, irqOut}, 32'h0);
    rstN = 1'b1; waitCycles(1);
    busRead(ADDR_RISEHI, d); check("R1 mask after reset", d, 32'h0);
    busRead(ADDR_CTRL, d);   check("R1 ctrl after reset", d, 32'h0);

    finished = 1;
    summary();
  end
endmodule